// File: doc/BRIEF.md
# Codec Channel Test-Mode Path Controller

This block sits between a voice channel's time-slot interface and its signal-processing chain. It takes the channel's test-control bits and steers the digital samples to match. On the receive side it can swap the incoming sample for a test tone, halve the sample, or force it to zero. On the transmit side it can replace the encoder sample with the receive sample looped back, either at the time-slot interface or after the full receive path. It can also cut the transmit side off the bus by releasing the pin drivers.

A capture register keeps the most recent transmit-path sample so a host can read it. When arming is enabled, each new sample raises an interrupt, and a host read clears it. The filters, the tone source, the companding and the analog routing live elsewhere. The block only selects, scales, gates and holds samples, and reports the filter-bypass request.

Top module: `tmode_path_ctrl`

## Requirements
- R1: While `ctl_cut_tx` is 1, `tx_oe` and `slot_oe` are 0 and `tx_out` is 0, whatever the loopback bits hold. While it is 0, both enables are 1 and `tx_out` equals the transmit-path sample.
- R2: While `ctl_cut_rx` is 1, `rx_out` and `fb_out` are 0, even with the tone or gain bits set. A full digital loopback active at the same time delivers 0 to the transmit path. While it is 0, `fb_out` equals `fb_data`.
- R3: `flt_bypass` equals `ctl_hp_off` in the same cycle.
- R4: With `ctl_gain_low` set and receive cutoff clear, `rx_out` is the selected receive sample arithmetically shifted right by one bit, which is 6.02 dB of loss.
- R5: With `ctl_tone` set and receive cutoff clear, the selected receive sample is `tone_data` instead of `rx_ts_data`.
- R6: With `ctl_ts_loop` set, the transmit-path sample is the raw `rx_ts_data`, untouched by tone, gain or receive cutoff. It overrides both the encoder sample and full digital loopback.
- R7: Full digital loopback is active when `ctl_dig_loop` is 1 or when `imp_code` equals 5'b10000. No other `imp_code` value has this effect. While active and time-slot loopback is clear, the transmit-path sample equals `rx_out`. Otherwise, with time-slot loopback clear, it equals `tx_enc_data`.
- R8: On a clock edge with `tx_new` high, the transmit-path sample of that cycle is stored. It appears on `rd_data` from the next cycle, and cutoff-transmit does not affect this.
- R9: With `ctl_irq_arm` set, `tx_new` makes `irq` 1 in the next cycle. `pcm_rd` without `tx_new` makes it 0 in the next cycle.
- R10: With `ctl_irq_arm` clear at an edge, `irq` is 0 in the next cycle.
- R11: If `tx_new` arrives while `irq` is pending, the stored sample is replaced and `irq` stays 1. This includes the case where `pcm_rd` is high in the same cycle.
- R12: After a synchronous reset, `irq` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_cut_tx | input | 1 | Cut off transmit side |
| ctl_cut_rx | input | 1 | Cut off receive side |
| ctl_hp_off | input | 1 | Request high-pass/notch bypass |
| ctl_gain_low | input | 1 | Apply 6.02 dB receive loss |
| ctl_tone | input | 1 | Replace receive sample with tone |
| ctl_ts_loop | input | 1 | Time-slot loopback |
| ctl_dig_loop | input | 1 | Full digital loopback |
| ctl_irq_arm | input | 1 | Arm transmit-sample interrupt |
| imp_code | input | 5 | Impedance-scaling code; 5'b10000 forces digital loopback |
| rx_ts_data | input | W | Receive sample from time-slot interface |
| tx_enc_data | input | W | Transmit sample from encoder side |
| tone_data | input | W | Tone sample |
| fb_data | input | W | B-filter feedback sample |
| tx_new | input | 1 | New transmit sample strobe |
| pcm_rd | input | 1 | Host read of captured transmit sample |
| rx_out | output | W | Steered receive sample to low-pass stage |
| fb_out | output | W | Gated feedback sample |
| tx_out | output | W | Transmit sample to time-slot interface |
| tx_oe | output | 1 | Transmit data pin drive enable |
| slot_oe | output | 1 | Time-slot control pin drive enable |
| flt_bypass | output | 1 | High-pass/notch bypass flag |
| rd_data | output | W | Captured transmit sample |
| irq | output | 1 | Transmit-sample interrupt |

## Verification
The bench sets several test bits at once to stress the precedence rules. Cutoff-transmit combined with both loopbacks must still leave the pins undriven; a design that gave a loopback priority would drive them. Receive cutoff combined with tone and digital loopback must deliver zeros on both sides; a design that gated only the receive output would leak the tone into transmit. An impedance code one bit away from 5'b10000 must not enter loopback. The bench also covers a read arriving in the same cycle as a new sample, and disarming while a sample is pending. A wrong result in the first case drops the interrupt and loses the new sample. In the second, the interrupt sticks high.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

    localparam int IMP_W = 5;
    localparam logic [IMP_W-1:0] IMP_FDL_CODE = 5'b10000;

    typedef struct packed {
        logic cut_tx;
        logic cut_rx;
        logic hp_off;
        logic gain_low;
        logic tone;
        logic ts_loop;
        logic dig_loop;
        logic irq_arm;
    } tmode_ctl_t;

    typedef enum logic [1:0] {
        TX_SRC_ENC  = 2'd0,
        TX_SRC_FDL  = 2'd1,
        TX_SRC_TSLP = 2'd2
    } tx_src_e;

    function automatic logic fdl_active(tmode_ctl_t c, logic [IMP_W-1:0] code);
        return c.dig_loop || (code == IMP_FDL_CODE);
    endfunction

    function automatic tx_src_e pick_tx_src(tmode_ctl_t c, logic [IMP_W-1:0] code);
        if (c.ts_loop)
            return TX_SRC_TSLP;
        else if (fdl_active(c, code))
            return TX_SRC_FDL;
        return TX_SRC_ENC;
    endfunction

endpackage

// File: rtl/tmode_rx_steer.sv
module tmode_rx_steer
    import tmode_pkg::*;
#(
    parameter int W = 16
) (
    input  tmode_ctl_t   ctl,
    input  logic [W-1:0] rx_in,
    input  logic [W-1:0] tone_in,
    input  logic [W-1:0] fb_in,
    output logic [W-1:0] rx_path,
    output logic [W-1:0] fb_path
);
    logic [W-1:0] src;
    logic [W-1:0] scaled;

    always_comb begin
        src = ctl.tone ? tone_in : rx_in;
        if (ctl.gain_low)
            scaled = {src[W-1], src[W-1:1]};
        else
            scaled = src;
        rx_path = ctl.cut_rx ? '0 : scaled;
        fb_path = ctl.cut_rx ? '0 : fb_in;
    end
endmodule

// File: rtl/tmode_tx_steer.sv
module tmode_tx_steer
    import tmode_pkg::*;
#(
    parameter int W = 16
) (
    input  tmode_ctl_t       ctl,
    input  logic [IMP_W-1:0] imp,
    input  logic [W-1:0]     rx_raw,
    input  logic [W-1:0]     rx_path,
    input  logic [W-1:0]     enc_in,
    output logic [W-1:0]     tx_path,
    output logic [W-1:0]     tx_pin,
    output logic             oe_data,
    output logic             oe_slot
);
    tx_src_e sel;

    always_comb begin
        sel = pick_tx_src(ctl, imp);
        unique case (sel)
            TX_SRC_TSLP: tx_path = rx_raw;
            TX_SRC_FDL:  tx_path = rx_path;
            default:     tx_path = enc_in;
        endcase
        oe_data = !ctl.cut_tx;
        oe_slot = !ctl.cut_tx;
        tx_pin  = ctl.cut_tx ? '0 : tx_path;
    end
endmodule

// File: rtl/tmode_pcm_capture.sv
module tmode_pcm_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         smp_new,
    input  logic         host_rd,
    input  logic [W-1:0] smp,
    output logic [W-1:0] held,
    output logic         pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            pend <= 1'b0;
        end else begin
            if (smp_new)
                held <= smp;
            if (!arm)
                pend <= 1'b0;
            else if (smp_new)
                pend <= 1'b1;
            else if (host_rd)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/tmode_path_ctrl.sv
module tmode_path_ctrl
    import tmode_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_cut_tx,
    input  logic             ctl_cut_rx,
    input  logic             ctl_hp_off,
    input  logic             ctl_gain_low,
    input  logic             ctl_tone,
    input  logic             ctl_ts_loop,
    input  logic             ctl_dig_loop,
    input  logic             ctl_irq_arm,
    input  logic [IMP_W-1:0] imp_code,
    input  logic [W-1:0]     rx_ts_data,
    input  logic [W-1:0]     tx_enc_data,
    input  logic [W-1:0]     tone_data,
    input  logic [W-1:0]     fb_data,
    input  logic             tx_new,
    input  logic             pcm_rd,
    output logic [W-1:0]     rx_out,
    output logic [W-1:0]     fb_out,
    output logic [W-1:0]     tx_out,
    output logic             tx_oe,
    output logic             slot_oe,
    output logic             flt_bypass,
    output logic [W-1:0]     rd_data,
    output logic             irq
);
    tmode_ctl_t   ctl;
    logic [W-1:0] rx_path;
    logic [W-1:0] tx_path;

    always_comb begin
        ctl.cut_tx   = ctl_cut_tx;
        ctl.cut_rx   = ctl_cut_rx;
        ctl.hp_off   = ctl_hp_off;
        ctl.gain_low = ctl_gain_low;
        ctl.tone     = ctl_tone;
        ctl.ts_loop  = ctl_ts_loop;
        ctl.dig_loop = ctl_dig_loop;
        ctl.irq_arm  = ctl_irq_arm;
    end

    assign flt_bypass = ctl.hp_off;
    assign rx_out     = rx_path;

    tmode_rx_steer #(.W(W)) u_rx (
        .ctl     (ctl),
        .rx_in   (rx_ts_data),
        .tone_in (tone_data),
        .fb_in   (fb_data),
        .rx_path (rx_path),
        .fb_path (fb_out)
    );

    tmode_tx_steer #(.W(W)) u_tx (
        .ctl     (ctl),
        .imp     (imp_code),
        .rx_raw  (rx_ts_data),
        .rx_path (rx_path),
        .enc_in  (tx_enc_data),
        .tx_path (tx_path),
        .tx_pin  (tx_out),
        .oe_data (tx_oe),
        .oe_slot (slot_oe)
    );

    tmode_pcm_capture #(.W(W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .arm     (ctl.irq_arm),
        .smp_new (tx_new),
        .host_rd (pcm_rd),
        .smp     (tx_path),
        .held    (rd_data),
        .pend    (irq)
    );
endmodule

// File: rtl/tmode_path_ctrl_chk.sv
module tmode_path_ctrl_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         ctl_cut_tx,
    input logic         ctl_cut_rx,
    input logic         ctl_ts_loop,
    input logic         ctl_irq_arm,
    input logic [W-1:0] rx_ts_data,
    input logic         tx_new,
    input logic         pcm_rd,
    input logic [W-1:0] rx_out,
    input logic [W-1:0] fb_out,
    input logic [W-1:0] tx_out,
    input logic         tx_oe,
    input logic         slot_oe,
    input logic [W-1:0] rd_data,
    input logic         irq
);
    // R1
    cut_tx_float_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cut_tx |-> (!tx_oe && !slot_oe && tx_out == '0));

    // R2
    cut_rx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_cut_rx |-> (rx_out == '0 && fb_out == '0));

    // R6
    ts_loop_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_ts_loop && !ctl_cut_tx) |-> (tx_out == rx_ts_data));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_new && ctl_ts_loop) |=> (rd_data == $past(rx_ts_data)));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_irq_arm && tx_new) |=> irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pcm_rd && !tx_new) |=> !irq);

    // R10
    irq_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_irq_arm |=> !irq);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && ctl_irq_arm && tx_new && pcm_rd) |=> irq);
endmodule

bind tmode_path_ctrl tmode_path_ctrl_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_cut_tx  (ctl_cut_tx),
    .ctl_cut_rx  (ctl_cut_rx),
    .ctl_ts_loop (ctl_ts_loop),
    .ctl_irq_arm (ctl_irq_arm),
    .rx_ts_data  (rx_ts_data),
    .tx_new      (tx_new),
    .pcm_rd      (pcm_rd),
    .rx_out      (rx_out),
    .fb_out      (fb_out),
    .tx_out      (tx_out),
    .tx_oe       (tx_oe),
    .slot_oe     (slot_oe),
    .rd_data     (rd_data),
    .irq         (irq)
);

// File: tb/tmode_path_ctrl_test.sv
`timescale 1ns/1ps
module tmode_path_ctrl_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cut_tx = 0, cut_rx = 0, hp_off = 0, gain_low = 0, tone = 0;
    logic ts_loop = 0, dig_loop = 0, arm = 0;
    logic [4:0] imp = '0;
    logic [W-1:0] rx_d = '0, enc_d = '0, tone_d = '0, fb_d = '0;
    logic tx_new = 0, pcm_rd = 0;

    logic [W-1:0] rx_out, fb_out, tx_out, rd_data;
    logic tx_oe, slot_oe, flt_bypass, irq;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [W-1:0] m_hold = '0;
    logic         m_irq = 1'b0;

    always #4 clk = ~clk;

    tmode_path_ctrl #(.W(W)) uut (
        .clk(clk), .rst(rst),
        .ctl_cut_tx(cut_tx), .ctl_cut_rx(cut_rx), .ctl_hp_off(hp_off),
        .ctl_gain_low(gain_low), .ctl_tone(tone), .ctl_ts_loop(ts_loop),
        .ctl_dig_loop(dig_loop), .ctl_irq_arm(arm), .imp_code(imp),
        .rx_ts_data(rx_d), .tx_enc_data(enc_d), .tone_data(tone_d), .fb_data(fb_d),
        .tx_new(tx_new), .pcm_rd(pcm_rd),
        .rx_out(rx_out), .fb_out(fb_out), .tx_out(tx_out), .tx_oe(tx_oe),
        .slot_oe(slot_oe), .flt_bypass(flt_bypass), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [W-1:0] exp_rx();
        logic [W-1:0] s;
        s = tone ? tone_d : rx_d;
        if (gain_low) s = {s[W-1], s[W-1:1]};
        return cut_rx ? '0 : s;
    endfunction

    function automatic logic [W-1:0] exp_txp();
        if (ts_loop) return rx_d;
        if (dig_loop || imp == 5'b10000) return exp_rx();
        return enc_d;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // inputs are set just after a negedge; check comb, step one clock, check state
    task automatic cycle();
        #1;
        chk("R3", 32'(flt_bypass), 32'(hp_off));
        chk("R1 oe", 32'({tx_oe, slot_oe}), cut_tx ? 32'd0 : 32'd3);
        chk("R1 R6 R7 tx", 32'(tx_out), cut_tx ? 32'd0 : 32'(exp_txp()));
        chk("R2 R4 R5 rx", 32'(rx_out), 32'(exp_rx()));
        chk("R2 fb", 32'(fb_out), cut_rx ? 32'd0 : 32'(fb_d));
        @(posedge clk);
        if (rst) begin
            m_hold = '0;
            m_irq = 1'b0;
        end else begin
            if (tx_new) m_hold = exp_txp();
            if (!arm) m_irq = 1'b0;
            else if (tx_new) m_irq = 1'b1;
            else if (pcm_rd) m_irq = 1'b0;
        end
        @(negedge clk);
        chk("R8 R11 rd_data", 32'(rd_data), 32'(m_hold));
        chk("R9 R10 R11 irq", 32'(irq), 32'(m_irq));
    endtask

    task automatic set_ctl(logic [7:0] b);
        {cut_tx, cut_rx, hp_off, gain_low, tone, ts_loop, dig_loop, arm} = b;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rst = 1;
        cycle();
        cycle();
        // R12 reset state
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 rd_data", 32'(rd_data), 32'd0);
        rst = 0;
        rx_d = 16'h8642; enc_d = 16'h1357; tone_d = 16'hC001; fb_d = 16'h0F0F;

        // R1: cutoff wins over both loopbacks
        set_ctl(8'b1000_0110); cycle();
        // R2: receive cutoff with tone, gain and digital loopback
        set_ctl(8'b0101_1010); cycle();
        // R4 R5: tone with negative sample halved
        set_ctl(8'b0001_1000); cycle();
        // R7: impedance code forces loopback; neighbouring code does not
        set_ctl(8'b0000_0000); imp = 5'b10000; cycle();
        imp = 5'b10001; cycle();
        imp = 5'b00000;
        // R6: time-slot loopback beats digital loopback and tone
        set_ctl(8'b0001_1110); cycle();

        // R9 R11: armed capture, overwrite while pending, read with new sample
        set_ctl(8'b0000_0001); tx_new = 1; enc_d = 16'h1111; cycle();
        enc_d = 16'h2222; cycle();
        pcm_rd = 1; enc_d = 16'h3333; cycle();
        chk("R11 still pending", 32'(irq), 32'd1);
        tx_new = 0; cycle();
        chk("R9 cleared", 32'(irq), 32'd0);
        pcm_rd = 0;
        // R10: disarm while pending
        tx_new = 1; enc_d = 16'h4444; cycle();
        tx_new = 0; arm = 0; cycle();
        chk("R10 disarmed", 32'(irq), 32'd0);
        // R8: capture under cutoff-transmit
        set_ctl(8'b1000_0000); tx_new = 1; enc_d = 16'h5A5A; cycle();
        tx_new = 0; cycle();
        chk("R8 capture under cutoff", 32'(rd_data), 32'h5A5A);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b;
            b = 8'($urandom) & 8'($urandom);
            b[0] = ($urandom % 4) != 0;
            set_ctl(b);
            imp = (($urandom % 6) == 0) ? 5'b10000 : 5'($urandom);
            rx_d = 16'($urandom); enc_d = 16'($urandom);
            tone_d = 16'($urandom); fb_d = 16'($urandom);
            tx_new = ($urandom % 3) == 0;
            pcm_rd = ($urandom % 3) == 0;
            rst = ($urandom % 500) == 0;
            cycle();
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule